// File: doc/BRIEF.md
# Masked Content-Addressable Search Array

This block is a small associative store. It holds a set of words and compares every stored word against a search key at the same time. A per-bit enable pattern decides which bit columns take part in the comparison. The outcome is a per-word match vector, which builds up in a current-match register. Each new search first moves the match vector into a previous-match register, so software can combine two search results without reading either one out.

A compile-time parameter picks how the comparison is done:

- **Single-step mode:** all enabled columns are checked in one cycle.
- **Column-walk mode:** one bit column is checked per cycle, from bit 0 upward. Each step narrows the match vector left by the step before it.

Priority logic outside the storage then reports whether any word matched, and the lowest-numbered matching word.

The host uses the block in this order. It fills the words through a write port. It loads the key and the enable pattern through register commands. It pulses `search_go`, waits for `result_valid`, and then reads `any_match`, `first_idx` and the full `match_vec`.

Top module: `assoc_search_array`

## Requirements
- R1: A write on `wr_en` stores `wr_data` at `addr`. A read on `rd_en` returns the stored word on `rd_data` on the clock edge after the request. `rd_data` holds its value between accepted reads.
- R2: A register command writes one register, chosen by `reg_sel`, and `reg_op` sets what is written. `reg_sel` values: 0 = key, 1 = column enable, 2 = current match, 3 = previous match. `reg_op` values: 0 = nothing, 1 = all ones, 2 = all zeros, 3 = load from `reg_word` (key and enable) or from `reg_pat` (match registers). A command is ignored while a search is running or being started.
- R3: When a search is accepted, on that edge the previous-match register takes the old current-match contents, and the current-match register becomes all ones.
- R4: In single-step mode (`SERIAL`=0), on the edge after acceptance, each word's match bit stays 1 only if the word equals the key in every column whose enable bit is 1.
- R5: In column-walk mode (`SERIAL`=1), step j (j = 0 up to WIDTH-1) clears the match bit of every word whose bit j differs from key bit j, but only if enable bit j is 1. A step on a disabled column leaves the vector unchanged.
- R6: `busy` rises on the acceptance edge. It stays high for 1 cycle in single-step mode and for WIDTH cycles in column-walk mode.
- R7: `result_valid` pulses for one cycle, one cycle after `busy` falls. With it, `any_match` is the OR of the match vector and `first_idx` is the lowest set position, or 0 when no bit is set. Both hold their value until the next result.
- R8: A write or read requested while `busy` is high, or in the same cycle as `search_go`, is refused. The stored word and `rd_data` are left unchanged.
- R9: `search_go` while `busy` is high is ignored. It neither restarts nor lengthens the running search.
- R10: After synchronous reset, all words, all four registers, `rd_data` and every result output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Word write request |
| rd_en | input | 1 | Word read request |
| addr | input | AW | Word address for read or write |
| wr_data | input | WIDTH | Word to store |
| rd_data | output | WIDTH | Word returned by the last accepted read |
| reg_sel | input | 2 | Register chosen by the command |
| reg_op | input | 2 | Register command code |
| reg_word | input | WIDTH | Load value for the key or enable register |
| reg_pat | input | WORDS | Load value for a match register |
| search_go | input | 1 | Start a search |
| busy | output | 1 | Search in progress |
| match_vec | output | WORDS | Current-match register |
| prev_vec | output | WORDS | Previous-match register |
| result_valid | output | 1 | One-cycle pulse when the priority result updates |
| any_match | output | 1 | At least one word matched |
| first_idx | output | AW | Lowest matching word |

## Verification
The assertions check three things on every cycle:

- On a search start, the match vector is preset to all ones and the previous-match register captures the old vector.
- While a search runs, the match vector never gains a bit.
- `result_valid` follows the falling edge of `busy`, and refused reads leave `rd_data` still.

Only the bench scenarios can show the values themselves: which words match under a given key and enable pattern, the lowest-index choice among several matches, the column-walk duration, and that refused writes never reach storage. The bench runs both modes side by side against a behavioural model.

// File: rtl/assoc_pkg.sv
// Shared command encodings for the associative search array.
package assoc_pkg;
    typedef enum logic [1:0] {
        SEL_KEY  = 2'd0,
        SEL_EN   = 2'd1,
        SEL_CUR  = 2'd2,
        SEL_PREV = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ONES = 2'd1,
        OP_ZERO = 2'd2,
        OP_LOAD = 2'd3
    } reg_op_e;
endpackage

// File: rtl/assoc_word_store.sv
// Word storage plus per-word compare logic.
// Assumes: accepted write/read strobes arrive already gated by the caller.
// SERIAL picks a full-width compare or a single-column compare at col_idx.
module assoc_word_store #(
    parameter int WORDS  = 8,
    parameter int WIDTH  = 8,
    parameter int SERIAL = 0,
    parameter int AW     = 3,
    parameter int IDXW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_acc,
    input  logic             rd_acc,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] col_en,
    input  logic [IDXW-1:0]  col_idx,
    output logic [WORDS-1:0] hit
);
    logic [WIDTH-1:0] mem [WORDS];

    // Storage update and registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
            rd_data <= '0;
        end else begin
            if (wr_acc) mem[addr] <= wr_data;
            if (rd_acc) rd_data <= mem[addr];
        end
    end

    generate
        if (SERIAL != 0) begin : g_column
            // One column per step: disabled column passes every word.
            always_comb begin
                for (int i = 0; i < WORDS; i++)
                    hit[i] = ~col_en[col_idx] | ~(mem[i][col_idx] ^ key[col_idx]);
            end
        end else begin : g_full
            logic unused_idx;
            assign unused_idx = ^col_idx;
            // Every enabled column at once.
            always_comb begin
                for (int i = 0; i < WORDS; i++)
                    hit[i] = ~|((mem[i] ^ key) & col_en);
            end
        end
    endgenerate
endmodule

// File: rtl/assoc_step_ctrl.sv
// Search sequencer: counts STEPS compare cycles after an accepted start.
// Assumes start is only raised while not busy.
module assoc_step_ctrl #(
    parameter int STEPS = 1,
    parameter int IDXW  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            busy,
    output logic [IDXW-1:0] step,
    output logic            last
);
    assign last = busy && (step == IDXW'(STEPS - 1));

    // Busy flag and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= '0;
        end else if (start) begin
            busy <= 1'b1;
            step <= '0;
        end else if (last) begin
            busy <= 1'b0;
        end else if (busy) begin
            step <= step + 1'b1;
        end
    end

    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(step) < STEPS)); // R6
endmodule

// File: rtl/assoc_first_hit.sv
// Lowest-index priority encoder over the match vector.
// Assumes nothing about the input; outputs index 0 when no bit is set.
module assoc_first_hit #(
    parameter int WORDS = 8,
    parameter int AW    = 3
) (
    input  logic [WORDS-1:0] vec,
    output logic             any,
    output logic [AW-1:0]    idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = WORDS - 1; i >= 0; i--)
            if (vec[i]) idx = AW'(i);
        any = |vec;
    end
endmodule

// File: rtl/assoc_search_array.sv
// Top of the masked associative search array.
// Holds the key, column-enable, current-match and previous-match registers.
// Assumes: single clock, synchronous active-low reset; SERIAL=1 walks columns.
module assoc_search_array #(
    parameter int WORDS  = 8,
    parameter int WIDTH  = 8,
    parameter int SERIAL = 0,
    localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    input  logic [1:0]       reg_sel,
    input  logic [1:0]       reg_op,
    input  logic [WIDTH-1:0] reg_word,
    input  logic [WORDS-1:0] reg_pat,
    input  logic             search_go,
    output logic             busy,
    output logic [WORDS-1:0] match_vec,
    output logic [WORDS-1:0] prev_vec,
    output logic             result_valid,
    output logic             any_match,
    output logic [AW-1:0]    first_idx
);
    import assoc_pkg::*;

    localparam int STEPS = (SERIAL != 0) ? WIDTH : 1;
    localparam int IDXW  = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [WIDTH-1:0] key_q, en_q;
    logic [WORDS-1:0] hit;
    logic [IDXW-1:0]  step;
    logic             last, done_q, start, idle_ok, enc_any;
    logic [AW-1:0]    enc_idx;
    reg_sel_e         sel;
    reg_op_e          op;

    assign start   = search_go && !busy;
    assign idle_ok = !busy && !search_go;
    assign sel     = reg_sel_e'(reg_sel);
    assign op      = reg_op_e'(reg_op);

    assoc_step_ctrl #(.STEPS(STEPS), .IDXW(IDXW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .step(step), .last(last)
    );

    assoc_word_store #(.WORDS(WORDS), .WIDTH(WIDTH), .SERIAL(SERIAL),
                       .AW(AW), .IDXW(IDXW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_acc(wr_en && idle_ok), .rd_acc(rd_en && idle_ok),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .key(key_q), .col_en(en_q), .col_idx(step), .hit(hit)
    );

    assoc_first_hit #(.WORDS(WORDS), .AW(AW)) u_prio (
        .vec(match_vec), .any(enc_any), .idx(enc_idx)
    );

    // Key and column-enable registers: commands only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
            en_q  <= '0;
        end else if (idle_ok && op != OP_NONE) begin
            if (sel == SEL_KEY)
                key_q <= (op == OP_ONES) ? '1 : (op == OP_ZERO) ? '0 : reg_word;
            if (sel == SEL_EN)
                en_q  <= (op == OP_ONES) ? '1 : (op == OP_ZERO) ? '0 : reg_word;
        end
    end

    // Current/previous match registers: preset on start, narrow while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_vec <= '0;
            prev_vec  <= '0;
        end else if (start) begin
            prev_vec  <= match_vec;
            match_vec <= '1;
        end else if (busy) begin
            match_vec <= match_vec & hit;
        end else if (idle_ok && op != OP_NONE) begin
            if (sel == SEL_CUR)
                match_vec <= (op == OP_ONES) ? '1 : (op == OP_ZERO) ? '0 : reg_pat;
            if (sel == SEL_PREV)
                prev_vec  <= (op == OP_ONES) ? '1 : (op == OP_ZERO) ? '0 : reg_pat;
        end
    end

    // Priority result registered one cycle after the search completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q       <= 1'b0;
            result_valid <= 1'b0;
            any_match    <= 1'b0;
            first_idx    <= '0;
        end else begin
            done_q       <= last;
            result_valid <= done_q;
            if (done_q) begin
                any_match <= enc_any;
                first_idx <= enc_idx;
            end
        end
    end

    AST_PRESET_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (match_vec == '1)); // R3
    AST_PREV_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (prev_vec == $past(match_vec))); // R3
    AST_NO_NEW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> ((match_vec & ~$past(match_vec)) == '0)); // R4
    AST_RESULT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> result_valid); // R7
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R7
    AST_READ_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> $stable(rd_data)); // R8
endmodule

// File: tb/assoc_search_array_bench.sv
module assoc_search_array_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int W  = 8;
    localparam int AW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, rd_en = 0, search_go = 0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wr_data = '0, reg_word = '0;
    logic [1:0]    reg_sel = '0, reg_op = '0;
    logic [N-1:0]  reg_pat = '0;

    logic [W-1:0]  rd_data [2];
    logic          busy [2], rv [2], anym [2];
    logic [N-1:0]  mv [2], pv [2];
    logic [AW-1:0] fi [2];

    int checks = 0, fails = 0, cycles = 0;
    int ser_busy_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assoc_search_array #(.WORDS(N), .WIDTH(W), .SERIAL(0)) u_assoc_search_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data[0]), .reg_sel(reg_sel), .reg_op(reg_op),
        .reg_word(reg_word), .reg_pat(reg_pat), .search_go(search_go), .busy(busy[0]),
        .match_vec(mv[0]), .prev_vec(pv[0]), .result_valid(rv[0]),
        .any_match(anym[0]), .first_idx(fi[0]));

    assoc_search_array #(.WORDS(N), .WIDTH(W), .SERIAL(1)) u_assoc_search_array_ser (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data[1]), .reg_sel(reg_sel), .reg_op(reg_op),
        .reg_word(reg_word), .reg_pat(reg_pat), .search_go(search_go), .busy(busy[1]),
        .match_vec(mv[1]), .prev_vec(pv[1]), .result_valid(rv[1]),
        .any_match(anym[1]), .first_idx(fi[1]));

    // Behavioural reference model, one copy per mode (0 = single-step, 1 = column-walk).
    logic [W-1:0] m_mem [2][N];
    logic [W-1:0] m_key [2], m_en [2], m_rd [2];
    logic [N-1:0] m_cur [2], m_prev [2];
    int           m_left [2], m_col [2], m_first [2];
    bit           m_fin [2], m_rv [2], m_any [2];

    function automatic logic [W-1:0] apply_w(int op, logic [W-1:0] old, logic [W-1:0] v);
        if (op == 1) return '1;
        if (op == 2) return '0;
        if (op == 3) return v;
        return old;
    endfunction

    function automatic logic [N-1:0] apply_p(int op, logic [N-1:0] old, logic [N-1:0] v);
        if (op == 1) return '1;
        if (op == 2) return '0;
        if (op == 3) return v;
        return old;
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                for (int i = 0; i < N; i++) m_mem[k][i] = '0;
                m_key[k] = '0; m_en[k] = '0; m_rd[k] = '0;
                m_cur[k] = '0; m_prev[k] = '0;
                m_left[k] = 0; m_col[k] = 0; m_first[k] = 0;
                m_fin[k] = 0; m_rv[k] = 0; m_any[k] = 0;
            end else begin
                m_rv[k] = m_fin[k];
                if (m_fin[k]) begin
                    m_any[k] = (m_cur[k] != 0);
                    m_first[k] = 0;
                    for (int i = N - 1; i >= 0; i--) if (m_cur[k][i]) m_first[k] = i;
                end
                m_fin[k] = 0;
                if (m_left[k] > 0) begin
                    for (int i = 0; i < N; i++) begin
                        if (k == 0) begin
                            for (int j = 0; j < W; j++)
                                if (m_en[k][j] && m_mem[k][i][j] != m_key[k][j]) m_cur[k][i] = 0;
                        end else if (m_en[k][m_col[k]] &&
                                     m_mem[k][i][m_col[k]] != m_key[k][m_col[k]]) begin
                            m_cur[k][i] = 0;
                        end
                    end
                    m_col[k]++;
                    m_left[k]--;
                    if (m_left[k] == 0) m_fin[k] = 1;
                end else if (search_go) begin
                    m_prev[k] = m_cur[k];
                    m_cur[k] = '1;
                    m_left[k] = (k == 0) ? 1 : W;
                    m_col[k] = 0;
                end else begin
                    case (reg_sel)
                        2'd0: m_key[k]  = apply_w(reg_op, m_key[k], reg_word);
                        2'd1: m_en[k]   = apply_w(reg_op, m_en[k], reg_word);
                        2'd2: m_cur[k]  = apply_p(reg_op, m_cur[k], reg_pat);
                        default: m_prev[k] = apply_p(reg_op, m_prev[k], reg_pat);
                    endcase
                    if (wr_en) m_mem[k][addr] = wr_data;
                    if (rd_en) m_rd[k] = m_mem[k][addr];
                end
            end
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output of both modes against the model on every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                check(rd_data[k] == m_rd[k], "R1 rd_data", int'(rd_data[k]), int'(m_rd[k]));
                check(mv[k] == m_cur[k], (k == 0) ? "R4 match_vec" : "R5 match_vec",
                      int'(mv[k]), int'(m_cur[k]));
                check(pv[k] == m_prev[k], "R3 prev_vec", int'(pv[k]), int'(m_prev[k]));
                check(busy[k] == (m_left[k] > 0), "R6 busy", int'(busy[k]), int'(m_left[k] > 0));
                check(rv[k] == m_rv[k], "R7 result_valid", int'(rv[k]), int'(m_rv[k]));
                check(anym[k] == m_any[k], "R7 any_match", int'(anym[k]), int'(m_any[k]));
                check(int'(fi[k]) == m_first[k], "R7 first_idx", int'(fi[k]), m_first[k]);
            end
        end
    end

    always @(posedge clk) begin
        if (rst_n && busy[1]) ser_busy_cnt++;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        wr_en = 1; addr = AW'(a); wr_data = W'(d); tick(); wr_en = 0;
    endtask

    task automatic rd(int a);
        rd_en = 1; addr = AW'(a); tick(); rd_en = 0;
    endtask

    task automatic regcmd(int s, int o, int wv, int pvv);
        reg_sel = 2'(s); reg_op = 2'(o); reg_word = W'(wv); reg_pat = N'(pvv);
        tick(); reg_op = 2'd0;
    endtask

    task automatic search_wait();
        search_go = 1; tick(); search_go = 0; tick(W + 3);
    endtask

    initial begin
        tick(3);
        // R10: reset state
        for (int k = 0; k < 2; k++) begin
            check(mv[k] == 0 && pv[k] == 0, "R10 match regs", int'(mv[k]), 0);
            check(busy[k] == 0 && rv[k] == 0 && rd_data[k] == 0, "R10 outputs",
                  int'(rd_data[k]), 0);
        end
        rst_n = 1; tick();

        wr(0, 8'h3C); wr(1, 8'hA5); wr(2, 8'h3D); wr(3, 8'hA5);
        for (int i = 4; i < N; i++) wr(i, i * 17);
        rd(1); tick();
        check(rd_data[0] == 8'hA5 && rd_data[1] == 8'hA5, "R1 read back", int'(rd_data[0]), 8'hA5);

        // Full-width key: two equal words, lowest reported
        regcmd(0, 3, 8'hA5, 0); regcmd(1, 1, 0, 0);
        search_wait();
        for (int k = 0; k < 2; k++) begin
            check(mv[k] == 8'b0000_1010, (k == 0) ? "R4 exact" : "R5 exact", int'(mv[k]), 8'h0A);
            check(anym[k] && fi[k] == 1, "R7 lowest of two", int'(fi[k]), 1);
        end

        // Upper nibble only; previous pattern kept
        regcmd(0, 3, 8'h30, 0); regcmd(1, 3, 8'hF0, 0);
        search_wait();
        for (int k = 0; k < 2; k++) begin
            check(mv[k] == 8'b0000_0101, (k == 0) ? "R4 masked" : "R5 masked", int'(mv[k]), 8'h05);
            check(pv[k] == 8'b0000_1010, "R3 previous kept", int'(pv[k]), 8'h0A);
            check(fi[k] == 0 && anym[k], "R7 index zero", int'(fi[k]), 0);
        end

        // No match at all
        regcmd(0, 1, 0, 0); regcmd(1, 1, 0, 0);
        search_wait();
        for (int k = 0; k < 2; k++)
            check(!anym[k] && fi[k] == 0 && mv[k] == 0, "R7 none", int'(mv[k]), 0);

        // Every column disabled: all words match
        regcmd(1, 2, 0, 0);
        search_wait();
        for (int k = 0; k < 2; k++)
            check(mv[k] == 8'hFF, (k == 0) ? "R4 all off" : "R5 all off", int'(mv[k]), 8'hFF);

        // Busy refusal, repeated start and column-walk length
        ser_busy_cnt = 0;
        search_go = 1; tick(); search_go = 0;
        wr(0, 8'h00);
        tick(2);
        search_go = 1; tick(); search_go = 0;
        tick(W + 4);
        check(ser_busy_cnt == W, "R9 column walk length", ser_busy_cnt, W);
        rd(0); tick();
        check(rd_data[0] == 8'h3C && rd_data[1] == 8'h3C, "R8 write refused",
              int'(rd_data[1]), 8'h3C);

        // Register commands on match registers
        regcmd(2, 2, 0, 0);
        check(mv[0] == 0 && mv[1] == 0, "R2 clear current", int'(mv[1]), 0);
        regcmd(3, 3, 0, 8'h5A);
        check(pv[0] == 8'h5A && pv[1] == 8'h5A, "R2 load previous", int'(pv[1]), 8'h5A);
        regcmd(2, 1, 0, 0);
        check(mv[0] == 8'hFF && mv[1] == 8'hFF, "R2 set current", int'(mv[1]), 8'hFF);

        // Command during a column walk is ignored by that instance only
        search_go = 1; tick(); search_go = 0;
        tick(2);
        regcmd(3, 2, 0, 0);
        check(pv[1] == 8'hFF, "R2 ignored while busy", int'(pv[1]), 8'hFF);
        check(pv[0] == 8'h00, "R2 applied when idle", int'(pv[0]), 0);
        tick(W + 3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule